// File: doc/BRIEF.md
# Background/Object Pixel Priority Mixer

This block sits at the output end of the background and object pixel queues. On each dot in which both queues are clocked, it takes the front pixel of each and picks one for display. It applies the object-enable control, the background-enable control (monochrome-compatible mode) or master-priority control (color mode), and the per-pixel priority attribute of the object pixel. On dots in which the queues stall, no pixel is produced.

The result is registered one dot after the clocked dot. It carries a 2-bit color ID, a flag naming the source queue so that a later stage can pick the right palette, and a valid strobe. Palette lookup and the queues themselves belong to other blocks.

Top module: `pix_mixer`

## Requirements
- R1: After reset, `pix_valid_o` is 0, `pix_color_o` is 0 and `pix_is_obj_o` is 0.
- R2: `pix_valid_o` is 1 exactly one cycle after a cycle with `shift_i`=1, and 0 one cycle after a cycle with `shift_i`=0. While it is 0, `pix_color_o` and `pix_is_obj_o` hold their previous values.
- R3: An object color ID of 0 is transparent. With such an object pixel the output is the background pixel, with `pix_is_obj_o`=0.
- R4: When `obj_en_i`=0, the object pixel is treated as color 0, so the background pixel is output with `pix_is_obj_o`=0.
- R5: In color mode (`color_mode_i`=1) with `bg_master_i`=0, the priority attribute and the background color are ignored. A non-transparent object pixel wins, otherwise the background pixel is output.
- R6: In monochrome-compatible mode (`color_mode_i`=0) with `bg_master_i`=0, the background color is forced to 0 and is output with `pix_is_obj_o`=0 whenever the object pixel does not win.
- R7: With `bg_master_i`=1 and a non-transparent, enabled object pixel: if `obj_prio_i`=1 and the background color is nonzero, the background pixel is output. Otherwise the object pixel is output.
- R8: `pix_is_obj_o`=1 means `pix_color_o` is the object color ID. `pix_is_obj_o`=0 means it is the background color ID, after any forcing to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_i | input | 1 | Both queues are clocked this dot |
| bg_color_i | input | 2 | Background front pixel color ID |
| obj_color_i | input | 2 | Object front pixel color ID |
| obj_prio_i | input | 1 | Object priority attribute (1 = behind nonzero background) |
| bg_master_i | input | 1 | Background enable (monochrome-compatible) or master priority (color mode) |
| obj_en_i | input | 1 | Object enable |
| color_mode_i | input | 1 | 1 = color mode, 0 = monochrome-compatible |
| pix_valid_o | output | 1 | Output pixel strobe |
| pix_color_o | output | 2 | Chosen color ID |
| pix_is_obj_o | output | 1 | 1 = object source, 0 = background source |

## Verification
The bench drives every input combination through the mixer, plus runs of stall dots between shift dots. It looks for these corner cases:
- Object color 0 with its priority bit set. A mixer that forgets transparency would output the object.
- Object enable clear with an opaque object. A mixer that gates late would leak the object.
- Color mode with master priority clear, with the priority bit set over a nonzero background. A mixer that applies the per-pixel rule there would wrongly pick the background.
- Monochrome-compatible mode with background disabled. A mixer that does not force the background to 0 would pass a nonzero background color, or let the priority rule hide an object behind a blank background.

// File: rtl/pix_mixer_pkg.sv
package pix_mixer_pkg;
  parameter int unsigned CID_W = 2;

  typedef logic [CID_W-1:0] cid_t;

  typedef struct packed {
    cid_t color;
    logic is_obj;
  } mix_pix_t;
endpackage

// File: rtl/pix_mix_gate.sv
module pix_mix_gate
  import pix_mixer_pkg::*;
(
  input  cid_t bg_color_i,
  input  cid_t obj_color_i,
  input  logic bg_master_i,
  input  logic obj_en_i,
  input  logic color_mode_i,
  output cid_t bg_eff_o,
  output cid_t obj_eff_o,
  output logic prio_on_o
);
  // Disabled objects look transparent.
  assign obj_eff_o = obj_en_i ? obj_color_i : '0;
  // Monochrome-compatible background disable forces color 0.
  assign bg_eff_o  = (!color_mode_i && !bg_master_i) ? cid_t'(0) : bg_color_i;
  // Color mode with master clear bypasses the per-pixel priority.
  assign prio_on_o = !(color_mode_i && !bg_master_i);
endmodule

// File: rtl/pix_mix_select.sv
module pix_mix_select
  import pix_mixer_pkg::*;
(
  input  cid_t     bg_eff_i,
  input  cid_t     obj_eff_i,
  input  logic     obj_prio_i,
  input  logic     prio_on_i,
  output mix_pix_t pix_o
);
  logic obj_opaque, bg_covers, obj_wins;

  always_comb begin
    obj_opaque = (obj_eff_i != '0);
    bg_covers  = prio_on_i && obj_prio_i && (bg_eff_i != '0);
    obj_wins   = obj_opaque && !bg_covers;
    pix_o.is_obj = obj_wins;
    pix_o.color  = obj_wins ? obj_eff_i : bg_eff_i;
  end
endmodule

// File: rtl/pix_mixer.sv
module pix_mixer
  import pix_mixer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [CID_W-1:0] bg_color_i,
  input  logic [CID_W-1:0] obj_color_i,
  input  logic             obj_prio_i,
  input  logic             bg_master_i,
  input  logic             obj_en_i,
  input  logic             color_mode_i,
  output logic             pix_valid_o,
  output logic [CID_W-1:0] pix_color_o,
  output logic             pix_is_obj_o
);
  cid_t     bg_eff, obj_eff;
  logic     prio_on;
  mix_pix_t sel_pix, out_q;
  logic     valid_q;

  pix_mix_gate u_gate (
    .bg_color_i  (bg_color_i),
    .obj_color_i (obj_color_i),
    .bg_master_i (bg_master_i),
    .obj_en_i    (obj_en_i),
    .color_mode_i(color_mode_i),
    .bg_eff_o    (bg_eff),
    .obj_eff_o   (obj_eff),
    .prio_on_o   (prio_on)
  );

  pix_mix_select u_sel (
    .bg_eff_i  (bg_eff),
    .obj_eff_i (obj_eff),
    .obj_prio_i(obj_prio_i),
    .prio_on_i (prio_on),
    .pix_o     (sel_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= shift_i;
      if (shift_i) out_q <= sel_pix;
    end
  end

  assign pix_valid_o  = valid_q;
  assign pix_color_o  = out_q.color;
  assign pix_is_obj_o = out_q.is_obj;

  assert_valid_follows_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pix_valid_o == $past(shift_i)));
  assert_hold_on_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> ($stable(pix_color_o) && $stable(pix_is_obj_o)));
  assert_transparent_obj_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && obj_color_i == '0) |=> !pix_is_obj_o);
  assert_obj_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !obj_en_i) |=> !pix_is_obj_o);
  assert_master_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && color_mode_i && !bg_master_i && obj_en_i && obj_color_i != '0)
      |=> (pix_is_obj_o && pix_color_o == $past(obj_color_i)));
  assert_bg_forced_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !color_mode_i && !bg_master_i) |=> (pix_is_obj_o || pix_color_o == '0));
  assert_bg_over_obj_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && bg_master_i && obj_prio_i && bg_color_i != '0)
      |=> (!pix_is_obj_o && pix_color_o == $past(bg_color_i)));
  assert_obj_color_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_is_obj_o |-> (pix_color_o != '0));
endmodule

// File: tb/pix_mixer_bench.sv
module pix_mixer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift = 1'b0;
  logic [1:0] bgc = '0, objc = '0;
  logic prio = 1'b0, master = 1'b0, oen = 1'b0, cmode = 1'b0;
  logic vld, isobj;
  logic [1:0] col;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] c;
    logic o;
    string req;
  } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;

  pix_mixer u_pix_mixer (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift),
    .bg_color_i(bgc), .obj_color_i(objc), .obj_prio_i(prio),
    .bg_master_i(master), .obj_en_i(oen), .color_mode_i(cmode),
    .pix_valid_o(vld), .pix_color_o(col), .pix_is_obj_o(isobj)
  );

  // Reference model written from the requirements.
  function automatic exp_t model(logic [1:0] b, logic [1:0] ob, logic p,
                                 logic m, logic e, logic cm);
    exp_t r;
    logic [1:0] be, oe;
    logic win;
    oe = e ? ob : 2'd0;                            // R4
    be = (!cm && !m) ? 2'd0 : b;                   // R6
    if (oe == 0) win = 1'b0;                       // R3
    else if (cm && !m) win = 1'b1;                 // R5
    else win = !(p && be != 0);                    // R7
    r.c = win ? oe : be;
    r.o = win;                                     // R8
    if (!e) r.req = "R4";
    else if (ob == 0) r.req = "R3";
    else if (cm && !m) r.req = "R5";
    else if (!cm && !m) r.req = "R6";
    else r.req = "R7";
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(logic [1:0] b, logic [1:0] ob, logic p, logic m,
                       logic e, logic cm);
    @(negedge clk);
    shift = 1'b1; bgc = b; objc = ob; prio = p; master = m; oen = e; cmode = cm;
    expq.push_back(model(b, ob, p, m, e, cm));
  endtask

  task automatic stall(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      shift = 1'b0; bgc = ~bgc; objc = ~objc; prio = ~prio;
    end
  endtask

  // Monitor: samples at negedge, one cycle after the shift dot.
  logic prev_shift = 1'b0;
  logic [1:0] last_c = '0;
  logic last_o = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(vld == prev_shift, "R2 valid", int'(vld), int'(prev_shift));
      if (vld) begin
        exp_t e;
        if (expq.size() == 0) check(1'b0, "R2 extra pixel", 1, 0);
        else begin
          e = expq.pop_front();
          check(col == e.c, {e.req, " color"}, int'(col), int'(e.c));
          check(isobj == e.o, {"R8 source/", e.req}, int'(isobj), int'(e.o));
        end
      end else begin
        check(col == last_c && isobj == last_o, "R2 hold", int'(col), int'(last_c));
      end
      last_c = col; last_o = isobj;
    end
    prev_shift = shift;
  end

  initial begin
    #1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vld == 0, "R1 valid", int'(vld), 0);
    check(col == 0, "R1 color", int'(col), 0);
    check(isobj == 0, "R1 source", int'(isobj), 0);
    rst_n = 1'b1;
    // Directed corners
    drive(2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);   // R3
    drive(2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);   // R4
    drive(2'd3, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1);   // R5
    drive(2'd3, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);   // R6
    drive(2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);   // R6 forced 0
    drive(2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);   // R7 bg wins
    drive(2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0);   // R7 obj wins
    stall(3);
    // Exhaustive sweep with periodic stalls
    for (int k = 0; k < 512; k++) begin
      drive(k[1:0], k[3:2], k[4], k[5], k[6], k[7]);
      if (k[8] && k[2:0] == 3'd5) stall(2);
    end
    stall(2);
    check(expq.size() == 0, "R2 drained", expq.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule